// File: doc/BRIEF.md
# Converter Power-Down and Frame-Sync Sequencer

This block sequences the digital side of a stereo sigma-delta audio converter through power-down, start-up and settling. A digital run input (high means operate, low means powered down) gates the whole conversion path. While it is low, the conversion enable, the frame strobe, the generated frame clock and the data-valid flag are all held low. When it goes high, the block either starts its internal frame divider at once (master) or first waits for a rising edge on each of the two external serial clocks (slave). In slave mode both external clocks pass through synchronizers into the master-clock domain before any edge is detected.

Once running, the block emits one frame strobe per frame period: either a short or a long multiple of the master clock, chosen by a mode input. In master mode it also drives a frame clock that is high for the first half of each frame. The data-valid flag stays low for a fixed number of frame periods after each release from digital power-down, and again after each release from analog power-down. Releasing analog power-down restarts the settling count from the full value, even if an earlier count was still running. The downstream decimation filters read the enable and the frame strobe. The serial output stage reads the valid flag.

Top module: `convPowerSeq`

## Requirements
- R1: While rstN is low at a clock edge, and until digRun is sampled high after it, convEn, dataValid, frameTick and frameClkOut are all 0.
- R2: Once digRun has been sampled low at a clock edge, convEn, dataValid, frameTick and frameClkOut are all 0 from that edge until digRun is next sampled high.
- R3: In master mode (masterMode=1 at release), convEn goes to 1 at the first clock edge that samples digRun high. No external clock edge is needed.
- R4: In slave mode (masterMode=0), convEn stays 0 until a rising edge on bitClkIn and a rising edge on frameClkIn have both been observed after release. It goes to 1 at the third clock edge after the later of the two input transitions.
- R5: Rising edges on bitClkIn or frameClkIn that occur while digital power-down is active do not count toward the slave start condition.
- R6: While convEn is 1, frameTick pulses for one cycle every SHORT_DIV cycles if wideFrame was 0 at release, or every LONG_DIV cycles if it was 1. The first pulse comes one full period after convEn rises. Changes on wideFrame or masterMode while running have no effect.
- R7: In master mode, frameClkOut is 1 for the first half of each frame period and 0 for the rest. In slave mode it stays 0.
- R8: dataValid rises exactly SETTLE_FRAMES frame periods after convEn rises. It is never 1 while convEn is 0.
- R9: After anaRun is sampled low at a clock edge, dataValid is 0. After anaRun returns high, dataValid rises on the edge that consumes the SETTLE_FRAMES-th frameTick seen with anaRun high. A re-assertion in the middle of the count restarts it.
- R10: Every release from digital power-down starts a fresh settling window and a fresh slave synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| digRun | input | 1 | Digital run, 0 = digital power-down |
| anaRun | input | 1 | Analog run, 0 = modulators powered down |
| wideFrame | input | 1 | Frame length select, 0 = SHORT_DIV, 1 = LONG_DIV |
| masterMode | input | 1 | 1 = generate frame clock, 0 = follow external clocks |
| bitClkIn | input | 1 | External bit clock (slave mode), asynchronous |
| frameClkIn | input | 1 | External frame clock (slave mode), asynchronous |
| convEn | output | 1 | Conversion enable for filters and clock generation |
| dataValid | output | 1 | Filter output valid |
| frameTick | output | 1 | One-cycle strobe at each frame boundary |
| frameClkOut | output | 1 | Generated frame clock (master mode) |

## Verification
The assertions assume that the external clocks are slow compared with the master clock, so each level lasts at least two master cycles and every rising edge survives the synchronizers. They also assume the frame divisors are at least two, so one frame strobe cannot follow another directly. The stimulus holds every external clock level for four or more master cycles. It changes inputs only just after an active edge, and it changes the mode inputs while running only to confirm that they are latched. Slave starts are driven with edges placed before release, between the two clocks and after release, so both the pre-release filtering and the exact start latency are exercised.

// File: rtl/convPowerSeqPkg.sv
package convPowerSeqPkg;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic runDiv;       // divider active, conversion running
    logic reloadSettle; // restart the settling window
    logic latchMode;    // capture mode inputs (only while off)
  } seqStrobe_t;

  // synchronized edge events from datapath to control
  typedef struct packed {
    logic bitRise;
    logic frameRise;
  } seqEdges_t;

endpackage

// File: rtl/convPowerSeqSyncEdge.sv
module convPowerSeqSyncEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut
);

  logic [STAGES-1:0] pipe;
  logic lastLevel;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '0;
        else       pipe <= asyncIn;
      end
    end else begin : gMulti
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= pipe[STAGES-1];
  end

  assign riseOut = pipe[STAGES-1] & ~lastLevel;

endmodule

// File: rtl/convPowerSeqCtrl.sv
module convPowerSeqCtrl
  import convPowerSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       digRun,
  input  logic       anaRun,
  input  logic       masterMode,
  input  seqEdges_t  edges,
  output seqStrobe_t strobes,
  output logic       convEn
);

  seqState_t state;
  logic bitSeen;
  logic frameSeen;
  logic bitNow;
  logic frameNow;

  assign bitNow   = bitSeen   | edges.bitRise;
  assign frameNow = frameSeen | edges.frameRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_OFF;
      bitSeen   <= 1'b0;
      frameSeen <= 1'b0;
    end else if (!digRun) begin
      state     <= SEQ_OFF;
      bitSeen   <= 1'b0;
      frameSeen <= 1'b0;
    end else begin
      unique case (state)
        SEQ_OFF: begin
          bitSeen   <= 1'b0;
          frameSeen <= 1'b0;
          state     <= masterMode ? SEQ_RUN : SEQ_WAIT;
        end
        SEQ_WAIT: begin
          bitSeen   <= bitNow;
          frameSeen <= frameNow;
          if (bitNow && frameNow) state <= SEQ_RUN;
        end
        SEQ_RUN: state <= SEQ_RUN;
        default: state <= SEQ_OFF;
      endcase
    end
  end

  always_comb begin
    strobes.runDiv       = (state == SEQ_RUN);
    strobes.reloadSettle = (state != SEQ_RUN) | ~anaRun | ~digRun;
    strobes.latchMode    = (state == SEQ_OFF);
  end

  assign convEn = (state == SEQ_RUN);

endmodule

// File: rtl/convPowerSeqDatapath.sv
module convPowerSeqDatapath
  import convPowerSeqPkg::*;
#(
  parameter int SHORT_DIV     = 256,
  parameter int LONG_DIV      = 384,
  parameter int SETTLE_FRAMES = 50,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wideFrame,
  input  logic       masterMode,
  input  logic       bitClkIn,
  input  logic       frameClkIn,
  input  seqStrobe_t strobes,
  output seqEdges_t  edges,
  output logic       frameTick,
  output logic       frameClkOut,
  output logic       dataValid
);

  localparam int MAX_DIV  = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV;
  localparam int CNT_W    = $clog2(MAX_DIV);
  localparam int SET_W    = $clog2(SETTLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DIV - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DIV - 1);
  localparam logic [CNT_W-1:0] SHORT_HALF = CNT_W'(SHORT_DIV / 2);
  localparam logic [CNT_W-1:0] LONG_HALF  = CNT_W'(LONG_DIV / 2);
  localparam logic [SET_W-1:0] SETTLE_INIT = SET_W'(SETTLE_FRAMES);

  logic bitRise;
  logic frameRise;

  convPowerSeqSyncEdge #(.STAGES(SYNC_STAGES)) uBitSync (
    .clk(clk), .rstN(rstN), .asyncIn(bitClkIn), .riseOut(bitRise)
  );
  convPowerSeqSyncEdge #(.STAGES(SYNC_STAGES)) uFrameSync (
    .clk(clk), .rstN(rstN), .asyncIn(frameClkIn), .riseOut(frameRise)
  );

  assign edges.bitRise   = bitRise;
  assign edges.frameRise = frameRise;

  // mode capture: follows inputs while off, frozen while running
  logic longSel;
  logic masterSel;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      longSel   <= 1'b0;
      masterSel <= 1'b0;
    end else if (strobes.latchMode) begin
      longSel   <= wideFrame;
      masterSel <= masterMode;
    end
  end

  // frame divider
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLast;
  logic [CNT_W-1:0] divHalf;
  logic             atLast;

  assign divLast = longSel ? LONG_LAST : SHORT_LAST;
  assign divHalf = longSel ? LONG_HALF : SHORT_HALF;
  assign atLast  = (divCnt == divLast);

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.runDiv) divCnt <= '0;
    else if (atLast)              divCnt <= '0;
    else                          divCnt <= divCnt + 1'b1;
  end

  assign frameTick   = strobes.runDiv & atLast;
  assign frameClkOut = strobes.runDiv & masterSel & (divCnt < divHalf);

  // settling window, counted in frames
  logic [SET_W-1:0] settleCnt;
  always_ff @(posedge clk) begin
    if (!rstN || strobes.reloadSettle)         settleCnt <= SETTLE_INIT;
    else if (frameTick && (settleCnt != '0))   settleCnt <= settleCnt - 1'b1;
  end

  assign dataValid = strobes.runDiv & (settleCnt == '0);

endmodule

// File: rtl/convPowerSeq.sv
module convPowerSeq
  import convPowerSeqPkg::*;
#(
  parameter int SHORT_DIV     = 256,
  parameter int LONG_DIV      = 384,
  parameter int SETTLE_FRAMES = 50,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic digRun,
  input  logic anaRun,
  input  logic wideFrame,
  input  logic masterMode,
  input  logic bitClkIn,
  input  logic frameClkIn,
  output logic convEn,
  output logic dataValid,
  output logic frameTick,
  output logic frameClkOut
);

  seqStrobe_t strobes;
  seqEdges_t  edges;

  convPowerSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .digRun(digRun), .anaRun(anaRun),
    .masterMode(masterMode), .edges(edges), .strobes(strobes), .convEn(convEn)
  );

  convPowerSeqDatapath #(
    .SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV),
    .SETTLE_FRAMES(SETTLE_FRAMES), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .wideFrame(wideFrame), .masterMode(masterMode),
    .bitClkIn(bitClkIn), .frameClkIn(frameClkIn), .strobes(strobes),
    .edges(edges), .frameTick(frameTick), .frameClkOut(frameClkOut),
    .dataValid(dataValid)
  );

endmodule

// File: rtl/convPowerSeqCheck.sv
module convPowerSeqCheck (
  input logic clk,
  input logic rstN,
  input logic digRun,
  input logic anaRun,
  input logic convEn,
  input logic dataValid,
  input logic frameTick,
  input logic frameClkOut
);

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !digRun |=> (!convEn && !dataValid && !frameTick && !frameClkOut));

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    !anaRun |=> !dataValid);

  assert_valid_needs_conv_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> convEn);

  assert_valid_rises_on_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(frameTick));

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> !frameTick);

  assert_fclk_needs_conv_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameClkOut |-> convEn);

endmodule

bind convPowerSeq convPowerSeqCheck uCheck (
  .clk(clk), .rstN(rstN), .digRun(digRun), .anaRun(anaRun), .convEn(convEn),
  .dataValid(dataValid), .frameTick(frameTick), .frameClkOut(frameClkOut)
);

// File: tb/convPowerSeq_test.sv
`timescale 1ns/100ps
module convPowerSeq_test;

  localparam int S = 8;
  localparam int L = 12;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rstN, digRun, anaRun, wideFrame, masterMode, bitClkIn, frameClkIn;
  logic convEn, dataValid, frameTick, frameClkOut;

  int total = 0;
  int bad = 0;
  bit monOn = 0;
  bit finished = 0;
  int expPeriod = S;
  bit expMaster = 1;

  always #2.5 clk = ~clk;

  convPowerSeq #(.SHORT_DIV(S), .LONG_DIV(L), .SETTLE_FRAMES(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .digRun(digRun), .anaRun(anaRun), .wideFrame(wideFrame),
    .masterMode(masterMode), .bitClkIn(bitClkIn), .frameClkIn(frameClkIn),
    .convEn(convEn), .dataValid(dataValid), .frameTick(frameTick), .frameClkOut(frameClkOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // sample point: 2 ns after an active edge
  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // drive point: 1 ns after an active edge
  task automatic drivePoint();
    @(posedge clk);
    #1;
  endtask

  // running reference: settle tracking, frame period, frame clock duty, idle state
  int refFrames = 0;
  int sinceTick = 0;
  int highCnt = 0;
  bit prevDig = 0;
  always @(negedge clk) begin
    if (monOn) begin
      if (!prevDig)
        check({convEn, dataValid, frameTick, frameClkOut} == 4'b0, "R2 idle",
              int'({convEn, dataValid, frameTick, frameClkOut}), 0);
      check(dataValid == (refFrames >= N), "R8/R9 valid window",
            int'(dataValid), int'(refFrames >= N));
      if (!digRun || !anaRun || !convEn) refFrames = 0;
      else if (frameTick) refFrames++;
      if (!convEn) begin
        sinceTick = 0;
        highCnt = 0;
      end else begin
        sinceTick++;
        if (frameClkOut) highCnt++;
        if (frameTick) begin
          check(sinceTick == expPeriod, "R6 frame period", sinceTick, expPeriod);
          check(highCnt == (expMaster ? expPeriod / 2 : 0), "R7 frame clock high time",
                highCnt, expMaster ? expPeriod / 2 : 0);
          sinceTick = 0;
          highCnt = 0;
        end
      end
      prevDig = digRun;
    end
  end

  task automatic runConfig(input bit m, input bit w);
    int k;
    drivePoint();
    digRun = 0; anaRun = 1; masterMode = m; wideFrame = w;
    bitClkIn = 0; frameClkIn = 0;
    repeat (4) @(posedge clk);
    #1;
    if (!m) begin
      frameClkIn = 1;          // edge inside power-down, must be ignored (R5)
      repeat (6) @(posedge clk);
      #1;
    end
    expPeriod = w ? L : S;
    expMaster = m;
    digRun = 1;
    if (m) begin
      waitEdges(1);
      check(convEn == 1'b1, "R3 master start", int'(convEn), 1);
    end else begin
      waitEdges(8);
      check(convEn == 1'b0, "R5 pre-release frame edge ignored", int'(convEn), 0);
      drivePoint();
      bitClkIn = 1;
      waitEdges(8);
      check(convEn == 1'b0, "R4 bit edge alone", int'(convEn), 0);
      drivePoint();
      frameClkIn = 0;
      repeat (4) @(posedge clk);
      #1;
      frameClkIn = 1;
      waitEdges(1);
      check(convEn == 1'b0, "R4 start latency edge1", int'(convEn), 0);
      waitEdges(1);
      check(convEn == 1'b0, "R4 start latency edge2", int'(convEn), 0);
      waitEdges(1);
      check(convEn == 1'b1, "R4 start latency edge3", int'(convEn), 1);
    end
    k = 0;
    while (!dataValid && k < 1000) begin
      waitEdges(1);
      k++;
    end
    check(k == N * expPeriod, "R8/R10 settle latency", k, N * expPeriod);
  endtask

  task automatic countTicksToValid(input string req);
    int t = 0;
    int guard = 0;
    waitEdges(1);
    while (!dataValid && guard < 1000) begin
      if (frameTick) t++;
      waitEdges(1);
      guard++;
    end
    check(t == N, req, t, N);
  endtask

  initial begin
    int gap;
    rstN = 0; digRun = 0; anaRun = 0; wideFrame = 0; masterMode = 0;
    bitClkIn = 0; frameClkIn = 0;
    waitEdges(4);
    check({convEn, dataValid, frameTick, frameClkOut} == 4'b0, "R1 reset state",
          int'({convEn, dataValid, frameTick, frameClkOut}), 0);
    drivePoint();
    rstN = 1;
    bitClkIn = 1; frameClkIn = 1;     // edges while off
    monOn = 1;
    waitEdges(6);
    check({convEn, dataValid, frameTick, frameClkOut} == 4'b0, "R1 stays off after reset",
          int'({convEn, dataValid, frameTick, frameClkOut}), 0);

    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        runConfig(m[0], w[0]);

    runConfig(1'b1, 1'b0);

    // R6: wideFrame and masterMode latched at release
    drivePoint();
    wideFrame = 1; masterMode = 0;
    waitEdges(1);
    while (!frameTick) waitEdges(1);
    gap = 0;
    do begin
      waitEdges(1);
      gap++;
    end while (!frameTick && gap < 100);
    check(gap == S, "R6 mode latched while running", gap, S);

    // R9: analog power-down
    drivePoint();
    anaRun = 0;
    waitEdges(1);
    check(dataValid == 1'b0 && convEn == 1'b1, "R9 valid drops, conversion stays",
          int'({dataValid, convEn}), 1);
    repeat (5) @(posedge clk);
    #1;
    anaRun = 1;
    countTicksToValid("R9 analog settle count");

    // R9: mid-count re-assertion restarts the count
    drivePoint();
    anaRun = 0;
    repeat (2) @(posedge clk);
    #1;
    anaRun = 1;
    waitEdges(1);
    while (!frameTick) waitEdges(1);
    drivePoint();
    anaRun = 0;
    repeat (2) @(posedge clk);
    #1;
    anaRun = 1;
    countTicksToValid("R9 restart after mid-count assertion");

    // R2: digital power-down forces idle
    drivePoint();
    digRun = 0;
    waitEdges(1);
    check({convEn, dataValid, frameTick, frameClkOut} == 4'b0, "R2 idle next edge",
          int'({convEn, dataValid, frameTick, frameClkOut}), 0);
    drivePoint();
    bitClkIn = 0; frameClkIn = 0;
    waitEdges(6);
    check({convEn, dataValid, frameTick, frameClkOut} == 4'b0, "R2 idle held",
          int'({convEn, dataValid, frameTick, frameClkOut}), 0);

    // R10: fresh windows after re-release, slave then master
    runConfig(1'b0, 1'b0);
    runConfig(1'b1, 1'b1);

    waitEdges(4);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule